// File: doc/BRIEF.md
# Core-Local 64-bit Cycle Counter with Consistent Split Readout

This block is a 64-bit free-running cycle counter that belongs to a single processor core. Software reaches it through three auxiliary-space registers. The counter value is split into a low word and a high word, and a control/status register sits beside them. A write to the control register switches counting on or off.

A 64-bit value cannot be read in one 32-bit access, so the block does not latch a snapshot. Instead, a small tracker watches each read pair. Reading the low word opens a tracking window, and reading the high word closes it. Either of two events spoils the pair:

- the core takes an interrupt while the window is open, or
- the low word carries into the high word before the high word has been read.

When the pair is spoiled, the top bit of the control register reads 0. Software reads low, then high, then control, and repeats the sequence until that bit reads 1.

Top module: `core_tick64`

## Requirements
- R1: A synchronous reset loads the counter with the parameter `CNT_INIT` (default 0) and clears the enable, the consistency flag and the tracking window. A control read after reset returns 0.
- R2: A write to the control address (0x103) sets the enable from write-data bit 0 and ignores every other bit. Control read-data bit 0 returns the enable.
- R3: While enabled, the counter increases by exactly one on every clock edge. While disabled, it holds its value.
- R4: Address 0x103 reads control, 0x104 reads counter bits 31:0 and 0x105 reads counter bits 63:32. Read data is registered and valid the cycle after `rd_en`. It reflects the counter before that edge's increment. Any other address reads 0.
- R5: Writes to the low or high address have no effect on the counter or the enable.
- R6: A low read opens the tracking window and sets the consistency flag (control bit 31) to 1. The flag is set to 0 instead if the low word carries into the high word on that same edge.
- R7: If `irq_taken` is high in any cycle after the low read, up to and including the high read, the flag becomes 0.
- R8: If the low word carries into the high word on an edge after the low read and before the high read, the flag becomes 0. Consequently, the flag is 1 only when the high word read equals the high word at the time of the low read and no interrupt was taken.
- R9: A high read closes the window. A high read with no open window leaves the flag at 0.
- R10: A control read changes neither the flag nor the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Auxiliary register address |
| rd_en | input | 1 | Read strobe for `addr` |
| wr_en | input | 1 | Write strobe for `addr` |
| wr_data | input | WORD_W | Write data |
| irq_taken | input | 1 | Pulses when the core takes an interrupt or exception |
| rd_data | output | WORD_W | Registered read data |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the counter steps by one when enabled and holds when disabled;
- the enable follows control writes;
- low-read data matches the counter;
- the flag is cleared whenever an interrupt or a carry lands inside an open window;
- the window closes on a high read;
- a control read changes nothing.

Other behaviours can only be shown by the bench scenarios. The main one is the end-to-end promise that a flag of 1 really means the two words belong together. The bench shows this by sweeping the start point and the gap of a read pair across the low-to-high carry and comparing the flag with its own arithmetic. The scenarios also cover ignored data writes, an orphan high read and a repeated high read.

// File: rtl/tick64_pkg.sv
package tick64_pkg;
  localparam int AUX_CTRL = 'h103;
  localparam int AUX_LOW  = 'h104;
  localparam int AUX_HIGH = 'h105;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_LOW,
    SEL_HIGH
  } reg_sel_e;
endpackage

// File: rtl/tick64_count.sv
module tick64_count #(
  parameter int WORD_W = 32,
  parameter logic [2*WORD_W-1:0] CNT_INIT = '0,
  localparam int CNT_W = 2 * WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [CNT_W-1:0] cnt,
  output logic             carry
);
  // carry: the low half rolls over into the high half on this edge
  assign carry = en && (&cnt[WORD_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CNT_INIT;
    end else if (en) begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tick64_track.sv
module tick64_track (
  input  logic clk,
  input  logic rst,
  input  logic rd_low,
  input  logic rd_high,
  input  logic irq_taken,
  input  logic carry,
  output logic flag,
  output logic window
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= 1'b0;
      window <= 1'b0;
    end else if (rd_low) begin
      window <= 1'b1;
      flag   <= !carry;
    end else if (rd_high) begin
      window <= 1'b0;
      flag   <= window && flag && !irq_taken;
    end else if (window && (irq_taken || carry)) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tick64_regs.sv
module tick64_regs
  import tick64_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 12,
  parameter int CTRL_ADDR = AUX_CTRL,
  parameter int LOW_ADDR  = AUX_LOW,
  parameter int HIGH_ADDR = AUX_HIGH,
  localparam int CNT_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag,
  output logic              en,
  output logic              rd_low,
  output logic              rd_high,
  output logic [WORD_W-1:0] rd_data
);
  reg_sel_e sel;

  always_comb begin
    if (addr == ADDR_W'(CTRL_ADDR))      sel = SEL_CTRL;
    else if (addr == ADDR_W'(LOW_ADDR))  sel = SEL_LOW;
    else if (addr == ADDR_W'(HIGH_ADDR)) sel = SEL_HIGH;
    else                                 sel = SEL_NONE;
  end

  assign rd_low  = rd_en && (sel == SEL_LOW);
  assign rd_high = rd_en && (sel == SEL_HIGH);

  logic [WORD_W-1:0] ctrl_word;
  always_comb begin
    ctrl_word = '0;
    ctrl_word[WORD_W-1] = flag;
    ctrl_word[0] = en;
  end

  logic [WORD_W-1:0] rd_mux;
  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_mux = ctrl_word;
      SEL_LOW:  rd_mux = cnt[WORD_W-1:0];
      SEL_HIGH: rd_mux = cnt[CNT_W-1:WORD_W];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en      <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_en && (sel == SEL_CTRL)) en <= wr_data[0];
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/core_tick64.sv
module core_tick64
  import tick64_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 12,
  parameter int CTRL_ADDR = AUX_CTRL,
  parameter int LOW_ADDR  = AUX_LOW,
  parameter int HIGH_ADDR = AUX_HIGH,
  parameter logic [2*WORD_W-1:0] CNT_INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              irq_taken,
  output logic [WORD_W-1:0] rd_data
);
  localparam int CNT_W = 2 * WORD_W;

  logic [CNT_W-1:0] cnt_w;
  logic en_w, carry_w, flag_w, window_w, rd_low_w, rd_high_w;

  tick64_count #(.WORD_W(WORD_W), .CNT_INIT(CNT_INIT)) count_i (
    .clk(clk), .rst(rst), .en(en_w), .cnt(cnt_w), .carry(carry_w)
  );

  tick64_track track_i (
    .clk(clk), .rst(rst), .rd_low(rd_low_w), .rd_high(rd_high_w),
    .irq_taken(irq_taken), .carry(carry_w), .flag(flag_w), .window(window_w)
  );

  tick64_regs #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
    .LOW_ADDR(LOW_ADDR), .HIGH_ADDR(HIGH_ADDR)
  ) regs_i (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .cnt(cnt_w), .flag(flag_w), .en(en_w),
    .rd_low(rd_low_w), .rd_high(rd_high_w), .rd_data(rd_data)
  );
endmodule

// File: rtl/core_tick64_chk.sv
module core_tick64_chk #(
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 12,
  parameter int CTRL_ADDR = 'h103,
  parameter int LOW_ADDR  = 'h104
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   addr,
  input logic                rd_en,
  input logic                wr_en,
  input logic [WORD_W-1:0]   wr_data,
  input logic                irq_taken,
  input logic [WORD_W-1:0]   rd_data,
  input logic [2*WORD_W-1:0] cnt,
  input logic                en,
  input logic                carry,
  input logic                flag,
  input logic                window,
  input logic                rd_low,
  input logic                rd_high
);
  logic ctrl_rd, ctrl_wr, low_rd;
  assign ctrl_rd = rd_en && (addr == ADDR_W'(CTRL_ADDR));
  assign ctrl_wr = wr_en && (addr == ADDR_W'(CTRL_ADDR));
  assign low_rd  = rd_en && (addr == ADDR_W'(LOW_ADDR));

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!en && !flag && !window)); // R1
  AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (en == $past(wr_data[0]))); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    en |=> (cnt == $past(cnt) + 1'b1)); // R3
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt)); // R3
  AST_READ_LOW: assert property (@(posedge clk) disable iff (rst)
    low_rd |=> (rd_data == $past(cnt[WORD_W-1:0]))); // R4
  AST_LOW_OPENS: assert property (@(posedge clk) disable iff (rst)
    (rd_low && !carry) |=> (flag && window)); // R6
  AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (window && irq_taken && !rd_low) |=> !flag); // R7
  AST_CARRY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (window && carry && !rd_low && !rd_high) |=> !flag); // R8
  AST_HIGH_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (rd_high && !window) |=> (!window && !flag)); // R9
  AST_CTRL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rd && !(window && (irq_taken || carry))) |=> ($stable(flag) && $stable(window))); // R10
endmodule

bind core_tick64 core_tick64_chk #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .LOW_ADDR(LOW_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .wr_data(wr_data), .irq_taken(irq_taken), .rd_data(rd_data),
  .cnt(cnt_w), .en(en_w), .carry(carry_w), .flag(flag_w), .window(window_w),
  .rd_low(rd_low_w), .rd_high(rd_high_w)
);

// File: tb/core_tick64_tb_top.sv
`timescale 1ns/1ps
module core_tick64_tb_top;
  localparam logic [63:0] INIT = 64'h0000_0001_FFFF_FFE0;
  localparam logic [11:0] A_CTRL = 12'h103;
  localparam logic [11:0] A_LOW  = 12'h104;
  localparam logic [11:0] A_HIGH = 12'h105;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] addr = '0;
  logic rd_en = 1'b0, wr_en = 1'b0, irq_taken = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  core_tick64 #(.CNT_INIT(INIT)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .irq_taken(irq_taken), .rd_data(rd_data)
  );

  // arithmetic model of the counter value and enable from the requirements
  logic [63:0] mcnt;
  logic men;
  always @(posedge clk) begin
    if (rst) begin
      mcnt <= INIT;
      men  <= 1'b0;
    end else begin
      if (men) mcnt <= mcnt + 64'd1;
      if (wr_en && addr == A_CTRL) men <= wr_data[0];
    end
  end

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; v = rd_data;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  initial begin
    logic [31:0] v, e, hl;
    idle(1);
    do_reset();

    // R1 reset state
    rd(A_CTRL, v); check(v, 32'h0, "R1 ctrl after reset");
    rd(A_LOW, v);  check(v, INIT[31:0], "R1 low after reset");
    rd(A_HIGH, v); check(v, INIT[63:32], "R1 high after reset");

    // R4 unmapped
    rd(12'h106, v); check(v, 32'h0, "R4 unmapped address");

    // R9 orphan high read (counter disabled)
    do_reset();
    rd(A_HIGH, v); rd(A_CTRL, v); check(v, 32'h0, "R9 high without low");

    // R6 consistent pair while disabled, R10 repeated ctrl read
    rd(A_LOW, v); rd(A_HIGH, v);
    rd(A_CTRL, v); check(v, 32'h8000_0000, "R6 clean pair flag");
    rd(A_CTRL, v); check(v, 32'h8000_0000, "R10 second ctrl read keeps flag");

    // R9 second high read after window closed
    rd(A_LOW, v); rd(A_HIGH, v); rd(A_HIGH, v);
    rd(A_CTRL, v); check(v, 32'h0, "R9 repeated high read");

    // R7 interrupt inside the window
    rd(A_LOW, v);
    irq_taken = 1'b1; idle(1); irq_taken = 1'b0;
    rd(A_HIGH, v); rd(A_CTRL, v); check(v, 32'h0, "R7 irq between reads");

    // R7 interrupt in the high-read cycle
    rd(A_LOW, v);
    irq_taken = 1'b1; rd(A_HIGH, v); irq_taken = 1'b0;
    rd(A_CTRL, v); check(v, 32'h0, "R7 irq on high read");

    // R7 interrupt before the window has no effect
    irq_taken = 1'b1; idle(1); irq_taken = 1'b0;
    rd(A_LOW, v); rd(A_HIGH, v);
    rd(A_CTRL, v); check(v, 32'h8000_0000, "R7 irq before window ignored");

    // R2 enable write, other bits ignored
    wr(A_CTRL, 32'hFFFF_FFFE); rd(A_CTRL, v); check(v & 32'h1, 32'h0, "R2 bit0 clear keeps disabled");
    wr(A_CTRL, 32'h0000_0001); rd(A_CTRL, v); check(v & 32'h1, 32'h1, "R2 enable readback");

    // R3 counting, R4 read values
    for (int i = 0; i < 4; i++) begin
      e = mcnt[31:0]; rd(A_LOW, v); check(v, e, "R3 R4 low follows count");
    end

    // R5 data writes ignored
    e = mcnt[31:0] + 32'd2;
    wr(A_LOW, 32'h1234_5678);
    idle(1);
    rd(A_LOW, v); check(v, e, "R5 low write ignored");
    e = mcnt[63:32];
    wr(A_HIGH, 32'hDEAD_BEEF);
    rd(A_HIGH, v); check(v, e, "R5 high write ignored");

    // R3 disabled holds
    wr(A_CTRL, 32'h0);
    rd(A_LOW, e); idle(5);
    rd(A_LOW, v); check(v, e, "R3 hold while disabled");

    // R8 sweep of pair start and gap across the carry
    for (int d = 0; d < 40; d++) begin
      for (int g = 0; g < 4; g++) begin
        do_reset();
        wr(A_CTRL, 32'h1);
        idle(d);
        e = mcnt[31:0]; hl = mcnt[63:32];
        rd(A_LOW, v); check(v, e, "R4 sweep low");
        idle(g);
        e = mcnt[63:32];
        rd(A_HIGH, v); check(v, e, "R4 sweep high");
        rd(A_CTRL, v);
        check(v, {(e == hl), 30'h0, 1'b1}, "R8 sweep flag");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all-R actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule